// File: doc/BRIEF.md
# Supply-Loss Reset and Write-Protect Sequencer

This block turns two supply comparator outputs into the control signals a battery-backed memory needs when its supply fails and returns. One comparator reports that the supply is under the power-fail trip point. The other reports that it is under the lower battery switchover level. While the supply is under the trip point, the block write-protects the memory by deselecting it and pulls the shared reset line low. While the supply is under the switchover level, it tells the power switch to run from the battery.

When the supply recovers, battery selection follows the switchover comparator straight back. Deselect and reset are each released only after their own recovery interval, counted in system clock cycles. A new failure during either interval sends the sequencer back to the failed state, and both intervals start again from zero once the supply is good again.

Both comparator inputs are asynchronous. Each one passes through a two-flop synchronizer and then a persistence filter, so a spike shorter than the filter length is ignored. The analog comparators, the power switch and the pull-up resistor on the reset line sit outside this block.

Top module: `pfr_sequencer`

## Requirements
- R1: While the synchronous reset `rst` is high, `deselect_o`, `reset_pull_o` and `batt_sel_o` are all 1, which is the failed, on-battery state.
- R2: A trip comparator input held at 1 makes `deselect_o` and `reset_pull_o` both 1 after exactly 5 clock edges: 2 synchronizer stages, FILT_LEN = 2 filter stages and 1 sequencer register.
- R3: `batt_sel_o` follows the switchover comparator input after exactly 5 clock edges, in both directions, and the trip interval does not affect it.
- R4: After the trip input returns to 0, `deselect_o` stays 1 for 5 + DESEL_CYC edges and reads 0 after that.
- R5: After the trip input returns to 0, `reset_pull_o` stays 1 for 5 + RST_CYC edges and reads 0 after that.
- R6: A pulse on either comparator input that lasts fewer than FILT_LEN cycles has no effect. The outputs do not change, and a recovery interval already running keeps its timing.
- R7: If the trip input returns to 1 during a recovery interval, the block goes back to the failed state. Both intervals are then counted again in full from the next time the trip input falls.
- R8: `reset_pull_o` is an open-drain enable. A value of 1 means the reset line is driven low. A value of 0 means the line is released to high impedance, and the external pull-up then holds it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| supply_below_trip_i | input | 1 | Asynchronous comparator output: 1 when the supply is under the power-fail trip point |
| supply_below_switch_i | input | 1 | Asynchronous comparator output: 1 when the supply is under the battery switchover level |
| deselect_o | output | 1 | 1 while the memory is deselected and write-protected |
| batt_sel_o | output | 1 | 1 selects battery power at the power switch |
| reset_pull_o | output | 1 | Open-drain enable: 1 drives the reset line low, 0 releases it |

## Verification
The assertions assume that a comparator level, once accepted, stays put for at least FILT_LEN cycles after it leaves the synchronizer. The only exceptions are the deliberate short pulses. The assertions also assume that the trip and switchover inputs are independent levels and need not nest. The stimulus changes inputs only at falling edges. It holds every real level change for many cycles, and it shapes glitches as exactly one-cycle pulses, including one pulse that lands in the middle of a recovery interval. A new failure is applied well inside the deselect interval so that the restart of both counts can be observed.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

    localparam int NUM_CMP    = 2;
    localparam int CMP_TRIP   = 0;
    localparam int CMP_SWITCH = 1;

    typedef enum logic [1:0] {
        PF_DOWN    = 2'd0,
        PF_RECOVER = 2'd1,
        PF_UP      = 2'd2
    } pf_state_e;

    typedef struct packed {
        logic deselect;
        logic reset_pull;
        logic batt_sel;
    } pf_ctrl_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pfr_sync_filter.sv
module pfr_sync_filter #(
    parameter int FILT_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic meta_q, sync_q, filt_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            filt_q <= 1'b1;
            cnt_q  <= '0;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
            if (sync_q != filt_q) begin
                if (cnt_q == LAST) begin
                    filt_q <= sync_q;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign filt_o = filt_q;

    // R6: a filtered level only ever moves to the value the synchronizer held
    p_filter_follows_r6: assert property (@(posedge clk) disable iff (rst)
        (filt_q != $past(filt_q)) |-> ($past(sync_q) == filt_q));

    p_filter_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/pfr_seq.sv
module pfr_seq
    import pfr_pkg::*;
#(
    parameter int DESEL_CYC = 2_000_000,
    parameter int RST_CYC   = 5_000_000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     trip_f,
    input  logic     sw_f,
    output pf_ctrl_t ctrl_o
);
    localparam int MAXC = max_of(DESEL_CYC, RST_CYC);
    localparam int CW   = (MAXC < 1) ? 1 : $clog2(MAXC + 1);
    localparam logic [CW-1:0] MAXC_L  = CW'(MAXC);
    localparam logic [CW-1:0] DESEL_L = CW'(DESEL_CYC);
    localparam logic [CW-1:0] RST_L   = CW'(RST_CYC);

    pf_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic          batt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PF_DOWN;
            cnt_q   <= '0;
            batt_q  <= 1'b1;
        end else begin
            batt_q <= sw_f;
            unique case (state_q)
                PF_DOWN: begin
                    cnt_q <= '0;
                    if (!trip_f) state_q <= PF_RECOVER;
                end
                PF_RECOVER: begin
                    if (trip_f) begin
                        state_q <= PF_DOWN;
                        cnt_q   <= '0;
                    end else if (cnt_q == MAXC_L) begin
                        state_q <= PF_UP;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PF_UP: begin
                    cnt_q <= '0;
                    if (trip_f) state_q <= PF_DOWN;
                end
                default: state_q <= PF_DOWN;
            endcase
        end
    end

    always_comb begin
        ctrl_o.batt_sel   = batt_q;
        ctrl_o.deselect   = (state_q == PF_DOWN) ||
                            ((state_q == PF_RECOVER) && (cnt_q < DESEL_L));
        ctrl_o.reset_pull = (state_q == PF_DOWN) ||
                            ((state_q == PF_RECOVER) && (cnt_q < RST_L));
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (ctrl_o.deselect && ctrl_o.reset_pull && ctrl_o.batt_sel));

    p_fail_asserts_r2: assert property (@(posedge clk) disable iff (rst)
        trip_f |=> (ctrl_o.deselect && ctrl_o.reset_pull));

    p_batt_on_r3: assert property (@(posedge clk) disable iff (rst)
        sw_f |=> ctrl_o.batt_sel);

    p_batt_off_r3: assert property (@(posedge clk) disable iff (rst)
        !sw_f |=> !ctrl_o.batt_sel);

    p_desel_release_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_o.deselect) |-> $past(!trip_f));

    p_reset_release_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_o.reset_pull) |-> $past(!trip_f));

    p_refail_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == PF_RECOVER && trip_f) |=> (state_q == PF_DOWN && cnt_q == '0));

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= MAXC_L);

endmodule

// File: rtl/pfr_sequencer.sv
module pfr_sequencer
    import pfr_pkg::*;
#(
    parameter int DESEL_CYC = 2_000_000,
    parameter int RST_CYC   = 5_000_000,
    parameter int FILT_LEN  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_below_trip_i,
    input  logic supply_below_switch_i,
    output logic deselect_o,
    output logic batt_sel_o,
    output logic reset_pull_o
);
    logic [NUM_CMP-1:0] raw;
    logic [NUM_CMP-1:0] filt;
    pf_ctrl_t           ctrl;

    assign raw[CMP_TRIP]   = supply_below_trip_i;
    assign raw[CMP_SWITCH] = supply_below_switch_i;

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        pfr_sync_filter #(.FILT_LEN(FILT_LEN)) u_flt (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw[i]),
            .filt_o (filt[i])
        );
    end

    pfr_seq #(.DESEL_CYC(DESEL_CYC), .RST_CYC(RST_CYC)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .trip_f (filt[CMP_TRIP]),
        .sw_f   (filt[CMP_SWITCH]),
        .ctrl_o (ctrl)
    );

    assign deselect_o   = ctrl.deselect;
    assign reset_pull_o = ctrl.reset_pull;
    assign batt_sel_o   = ctrl.batt_sel;

    // R8: the open-drain enable is never released while deselect is still held
    //     when the reset interval is the longer one
    p_od_order_r8: assert property (@(posedge clk) disable iff (rst)
        ((RST_CYC >= DESEL_CYC) && !reset_pull_o) |-> !deselect_o);

endmodule

// File: tb/pfr_sequencer_bench.sv
module pfr_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DESEL = 20;
    localparam int RSTC  = 35;
    localparam int LAT   = 5;

    typedef struct {
        int cyc;
        int sig;   // 0 deselect, 1 reset_pull, 2 batt_sel
        bit val;
        int req;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trip = 1'b0;
    logic sw = 1'b0;
    logic deselect_o, batt_sel_o, reset_pull_o;
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    item_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pfr_sequencer #(.DESEL_CYC(DESEL), .RST_CYC(RSTC), .FILT_LEN(2)) u_pfr_sequencer (
        .clk(clk), .rst(rst),
        .supply_below_trip_i(trip), .supply_below_switch_i(sw),
        .deselect_o(deselect_o), .batt_sel_o(batt_sel_o), .reset_pull_o(reset_pull_o)
    );

    task automatic expect_at(input int c, input int sig, input bit v, input int req);
        item_t it;
        it.cyc = c; it.sig = sig; it.val = v; it.req = req;
        q.push_back(it);
    endtask

    // monitor: compare items due after the edge that just passed
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].cyc == cyc) begin
                logic act;
                act = (q[i].sig == 0) ? deselect_o :
                      (q[i].sig == 1) ? reset_pull_o : batt_sel_o;
                n_cmp++;
                if (act !== q[i].val) begin
                    n_bad++;
                    $display("FAIL R%0d sig=%0d cyc=%0d actual=%b expected=%b",
                             q[i].req, q[i].sig, cyc, act, q[i].val);
                end
                q.delete(i);
            end
        end
    end

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // recovery edges after trip falls at cycle c
    task automatic expect_recovery(input int c, input int rq_d, input int rq_r);
        expect_at(c + LAT + DESEL - 1, 0, 1'b1, rq_d);
        expect_at(c + LAT + DESEL,     0, 1'b0, rq_d);
        expect_at(c + LAT + RSTC - 1,  1, 1'b1, rq_r);
        expect_at(c + LAT + RSTC,      1, 1'b0, rq_r);
    endtask

    initial begin : driver
        int c;
        // R1: state held during reset
        repeat (2) @(negedge clk);
        expect_at(cyc + 1, 0, 1'b1, 1);
        expect_at(cyc + 1, 1, 1'b1, 1);
        expect_at(cyc + 1, 2, 1'b1, 1);
        repeat (3) @(negedge clk);
        rst = 1'b0; c = cyc;
        // R3 battery released, R4/R5 initial recovery
        expect_at(c + LAT - 1, 2, 1'b1, 3);
        expect_at(c + LAT,     2, 1'b0, 3);
        expect_recovery(c, 4, 5);
        drain();

        // R2 / R8: power fail asserts deselect and reset pull-low
        @(negedge clk); trip = 1'b1; c = cyc;
        expect_at(c + LAT - 1, 0, 1'b0, 2);
        expect_at(c + LAT,     0, 1'b1, 2);
        expect_at(c + LAT - 1, 1, 1'b0, 8);
        expect_at(c + LAT,     1, 1'b1, 8);
        drain();
        // R3: switchover in both directions while failed
        @(negedge clk); sw = 1'b1; c = cyc;
        expect_at(c + LAT - 1, 2, 1'b0, 3);
        expect_at(c + LAT,     2, 1'b1, 3);
        drain();
        @(negedge clk); sw = 1'b0; c = cyc;
        expect_at(c + LAT - 1, 2, 1'b1, 3);
        expect_at(c + LAT,     2, 1'b0, 3);
        drain();
        // R4/R5: recovery after fail
        @(negedge clk); trip = 1'b0; c = cyc;
        expect_recovery(c, 4, 5);
        drain();

        // R6: one-cycle glitches while up are ignored
        @(negedge clk); trip = 1'b1; sw = 1'b1; c = cyc;
        @(negedge clk); trip = 1'b0; sw = 1'b0;
        for (int k = 2; k <= 9; k++) begin
            expect_at(c + k, 0, 1'b0, 6);
            expect_at(c + k, 1, 1'b0, 6);
            expect_at(c + k, 2, 1'b0, 6);
        end
        drain();

        // R6: glitch inside a recovery interval keeps its timing
        @(negedge clk); trip = 1'b1;
        repeat (10) @(negedge clk);
        trip = 1'b0; c = cyc;
        expect_recovery(c, 6, 6);
        repeat (10) @(negedge clk);
        trip = 1'b1;
        @(negedge clk); trip = 1'b0;
        drain();

        // R7: new failure during recovery restarts both intervals
        @(negedge clk); trip = 1'b1;
        repeat (10) @(negedge clk);
        trip = 1'b0;
        repeat (10) @(negedge clk);
        trip = 1'b1; c = cyc;
        expect_at(c + LAT + 2, 0, 1'b1, 7);
        expect_at(c + LAT + 2, 1, 1'b1, 7);
        repeat (10) @(negedge clk);
        trip = 1'b0; c = cyc;
        expect_recovery(c, 7, 7);
        drain();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired at cyc=%0d actual=running expected=done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule